// File: doc/BRIEF.md
# Write enable and block protection unit

This unit decides whether the non-volatile side of a small serial memory may be programmed. It owns the write enable latch and the two block-protect bits. It also assembles the status byte that the serial front end shifts out. The front end reports decoded events as single-cycle pulses:
- enable set
- enable clear
- status data byte complete
- an extra serial bit
- chip-select rise
- array write commit with its target address

The unit answers with a start pulse for a status write or an array write. It also gives a combinational verdict on whether a queried address lies outside the protected region.

The unit also takes three other inputs: the active-low hardware write-protect pin, the busy flag of the programming sequencer, and two resets. The power-on reset clears the latch and all volatile state. The separate initialisation reset models the delivery state of the protect bits. The protect bits survive a power-on reset, as non-volatile cells would. A status write does not change the visible protect bits until its programming cycle ends. The new bits are held aside while the sequencer reports busy.

Top module: `wp_guard`

## Requirements
- R1: `status` reads bits 7..4 as 1, bit 3 as protect bit 1, bit 2 as protect bit 0, bit 1 as the write enable latch, and bit 0 as the `busy` input.
- R2: A `cmd_set_en` pulse with `wp_n` high sets the latch, and `wel` is 1 from the next cycle on.
- R3: The latch is 0 after power-on reset. It is cleared in the cycle after a `cmd_clr_en` pulse. It is also cleared in the cycle after any cycle with `wp_n` low, and a `cmd_set_en` in such a cycle has no effect.
- R4: `chk_ok` is 0 exactly for these addresses, and 1 for all others:
  - protect code 00: none;
  - code 01: 180h to 1FFh;
  - code 10: 100h to 1FFh;
  - code 11: every address.
- R5: `arr_go` pulses in the same cycle as `arr_commit` only when all of the following hold: the latch is set, `wp_n` is high, `busy` is low, and `arr_addr` is unprotected. A commit to a protected address starts nothing and leaves the latch set.
- R6: A cycle with `arr_go` clears the latch from the next cycle.
- R7: A `st_byte` pulse arms a status write, with the new protect bits taken from `st_data[3:2]`. The `sr_go` pulse comes at the next `cs_rise` only if all of the following hold: no `bit_tick` came in between, the latch is set, `wp_n` is high, and `busy` is low. A `bit_tick` after the byte discards the write. A cycle with `sr_go` clears the latch from the next cycle.
- R8: After `sr_go`, `status[3:2]` keeps the old protect bits while `busy` is high. The new bits appear in the cycle after the first cycle in which `busy` is seen low again.
- R9: `init_n` low sets the protect bits to 00. `por_n` low clears the latch but leaves the protect bits unchanged.
- R10: Once `sr_go` has fired, driving `wp_n` low during the programming cycle does not stop the new protect bits from being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears volatile state |
| init_n | input | 1 | Delivery-state reset of the protect bits, active low |
| wp_n | input | 1 | Hardware write-protect pin, low blocks writes |
| busy | input | 1 | Programming sequencer busy flag |
| cmd_set_en | input | 1 | Enable-set command pulse |
| cmd_clr_en | input | 1 | Enable-clear command pulse |
| st_byte | input | 1 | Eighth status data bit latched |
| st_data | input | 8 | Status data byte, valid with st_byte |
| bit_tick | input | 1 | A further serial bit latched while selected |
| cs_rise | input | 1 | Chip select rose |
| arr_commit | input | 1 | Array write ready to start at chip-select rise |
| arr_addr | input | 9 | First address of the pending array write |
| chk_addr | input | 9 | Address queried for writability |
| status | output | 8 | Status byte |
| chk_ok | output | 1 | chk_addr is outside the protected region |
| sr_go | output | 1 | Status write programming starts |
| arr_go | output | 1 | Array write programming starts |
| wel | output | 1 | Write enable latch |

## Verification
The assertions take for granted that the front end raises at most one event pulse per cycle. In particular, `st_byte` and `cs_rise` never coincide. They also assume that `busy` is raised by the sequencer only after a start pulse and stays high for at least one cycle. Under those conditions the protect bits must stay stable while `busy` is high, and the latch must follow each clearing event. The stimulus drives exactly one event per cycle on the falling clock edge. It imitates the sequencer by raising `busy` the cycle after each start pulse and dropping it a few cycles later.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  localparam int unsigned PROT_W = 2;
  localparam int unsigned SR_WEL_BIT = 1;
  localparam int unsigned SR_BP_LSB = 2;

  // Lowest address that a protect code guards. A value of 2**aw means
  // that no address in the array is guarded.
  function automatic int unsigned guard_floor(input logic [PROT_W-1:0] code,
                                              input int unsigned aw);
    int unsigned span;
    span = 32'd1 << aw;
    case (code)
      2'b00:   return span;
      2'b01:   return span - (span >> 2);
      2'b10:   return span >> 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic is_guarded(input logic [PROT_W-1:0] code,
                                      input int unsigned addr,
                                      input int unsigned aw);
    return addr >= guard_floor(code, aw);
  endfunction

  function automatic logic [7:0] build_status(input logic [PROT_W-1:0] code,
                                              input logic latch,
                                              input logic wip);
    return {4'hF, code, latch, wip};
  endfunction

endpackage

// File: rtl/wpg_latch.sv
module wpg_latch (
  input  logic clk,
  input  logic por_n,
  input  logic wp_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic go_any,
  output logic wel
);

  logic kill_evt;
  assign kill_evt = !wp_n || clr_req || go_any;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wel <= 1'b0;
    else if (kill_evt) wel <= 1'b0;
    else if (set_req)  wel <= 1'b1;
  end

  AST_PIN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !wp_n |=> !wel); // R3
  AST_CLR_CMD_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    clr_req |=> !wel); // R3
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    go_any |=> !wel); // R6
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!por_n)
    (set_req && wp_n && !clr_req && !go_any) |=> wel); // R2

endmodule

// File: rtl/wpg_bp_store.sv
module wpg_bp_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PROT_W = 2,
  parameter int unsigned BP_LSB = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              init_n,
  input  logic              st_byte,
  input  logic [DATA_W-1:0] st_data,
  input  logic              bit_tick,
  input  logic              cs_rise,
  input  logic              wel,
  input  logic              wp_n,
  input  logic              busy,
  output logic [PROT_W-1:0] bp,
  output logic              sr_go
);

  logic              armed;
  logic              prog_on;
  logic              busy_q;
  logic [PROT_W-1:0] pending_bp;
  logic              commit_evt;
  logic              may_start;

  assign may_start  = wel && wp_n && !busy;
  assign sr_go      = cs_rise && armed && !bit_tick && may_start;
  assign commit_evt = prog_on && busy_q && !busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   armed <= 1'b0;
    else if (bit_tick || cs_rise) armed <= 1'b0;
    else if (st_byte)             armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prog_on    <= 1'b0;
      busy_q     <= 1'b0;
      pending_bp <= '0;
    end else begin
      busy_q <= busy;
      if (st_byte && !prog_on) pending_bp <= st_data[BP_LSB +: PROT_W];
      if (sr_go)               prog_on <= 1'b1;
      else if (commit_evt)     prog_on <= 1'b0;
    end
  end

  // Non-volatile cells: only the delivery reset touches them.
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)         bp <= '0;
    else if (commit_evt) bp <= pending_bp;
  end

  AST_BP_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!por_n || !init_n)
    busy |=> $stable(bp)); // R8
  AST_BP_IDLE_STABLE: assert property (@(posedge clk) disable iff (!por_n || !init_n)
    (!prog_on && !sr_go) |=> $stable(bp)); // R8
  AST_TICK_DISCARDS: assert property (@(posedge clk) disable iff (!por_n)
    bit_tick |=> !sr_go); // R7

endmodule

// File: rtl/wpg_range.sv
module wpg_range #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned PROT_W = 2
) (
  input  logic [PROT_W-1:0] bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  import wpg_pkg::*;

  assign locked = is_guarded(bp, int'(addr), ADDR_W);
endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              init_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              cmd_set_en,
  input  logic              cmd_clr_en,
  input  logic              st_byte,
  input  logic [DATA_W-1:0] st_data,
  input  logic              bit_tick,
  input  logic              cs_rise,
  input  logic              arr_commit,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic [DATA_W-1:0] status,
  output logic              chk_ok,
  output logic              sr_go,
  output logic              arr_go
  ,output logic             wel
);
  import wpg_pkg::*;

  localparam int unsigned NQ = 2;

  logic [PROT_W-1:0]         bp;
  logic [NQ-1:0][ADDR_W-1:0] q_addr;
  logic [NQ-1:0]             q_lock;
  logic                      go_any;

  assign q_addr[0] = chk_addr;
  assign q_addr[1] = arr_addr;

  for (genvar gi = 0; gi < NQ; gi++) begin : g_rng
    wpg_range #(.ADDR_W(ADDR_W), .PROT_W(PROT_W)) u_rng (
      .bp     (bp),
      .addr   (q_addr[gi]),
      .locked (q_lock[gi])
    );
  end

  assign chk_ok = !q_lock[0];
  assign arr_go = arr_commit && wel && wp_n && !busy && !q_lock[1];
  assign go_any = arr_go || sr_go;

  wpg_latch u_latch (
    .clk     (clk),
    .por_n   (por_n),
    .wp_n    (wp_n),
    .set_req (cmd_set_en),
    .clr_req (cmd_clr_en),
    .go_any  (go_any),
    .wel     (wel)
  );

  wpg_bp_store #(.DATA_W(DATA_W), .PROT_W(PROT_W), .BP_LSB(SR_BP_LSB)) u_bp (
    .clk      (clk),
    .por_n    (por_n),
    .init_n   (init_n),
    .st_byte  (st_byte),
    .st_data  (st_data),
    .bit_tick (bit_tick),
    .cs_rise  (cs_rise),
    .wel      (wel),
    .wp_n     (wp_n),
    .busy     (busy),
    .bp       (bp),
    .sr_go    (sr_go)
  );

  assign status = DATA_W'(build_status(bp, wel, busy));

  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> !(arr_go || sr_go)); // R5
  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!por_n)
    go_any |-> (status[SR_WEL_BIT] && wp_n)); // R5
  AST_LOCKED_NO_ARRAY: assert property (@(posedge clk) disable iff (!por_n)
    (arr_commit && (arr_addr == chk_addr) && !chk_ok) |-> !arr_go); // R5

endmodule

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_n = 1'b0, init_n = 1'b0, wp_n = 1'b1, busy = 1'b0;
  logic cmd_set_en = 1'b0, cmd_clr_en = 1'b0, st_byte = 1'b0, bit_tick = 1'b0;
  logic cs_rise = 1'b0, arr_commit = 1'b0;
  logic [7:0] st_data = '0;
  logic [8:0] arr_addr = '0, chk_addr = '0;
  logic [7:0] status;
  logic chk_ok, sr_go, arr_go, wel;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  wp_guard u0 (.clk(clk), .por_n(por_n), .init_n(init_n), .wp_n(wp_n), .busy(busy),
    .cmd_set_en(cmd_set_en), .cmd_clr_en(cmd_clr_en), .st_byte(st_byte),
    .st_data(st_data), .bit_tick(bit_tick), .cs_rise(cs_rise),
    .arr_commit(arr_commit), .arr_addr(arr_addr), .chk_addr(chk_addr),
    .status(status), .chk_ok(chk_ok), .sr_go(sr_go), .arr_go(arr_go), .wel(wel));

  // {protect code, address, expected writable}
  localparam logic [11:0] VEC [24] = '{
    {2'd0,9'h000,1'b1},{2'd0,9'h0FF,1'b1},{2'd0,9'h100,1'b1},
    {2'd0,9'h17F,1'b1},{2'd0,9'h180,1'b1},{2'd0,9'h1FF,1'b1},
    {2'd1,9'h000,1'b1},{2'd1,9'h0FF,1'b1},{2'd1,9'h100,1'b1},
    {2'd1,9'h17F,1'b1},{2'd1,9'h180,1'b0},{2'd1,9'h1FF,1'b0},
    {2'd2,9'h000,1'b1},{2'd2,9'h0FF,1'b1},{2'd2,9'h100,1'b0},
    {2'd2,9'h17F,1'b0},{2'd2,9'h180,1'b0},{2'd2,9'h1FF,1'b0},
    {2'd3,9'h000,1'b0},{2'd3,9'h0FF,1'b0},{2'd3,9'h100,1'b0},
    {2'd3,9'h17F,1'b0},{2'd3,9'h180,1'b0},{2'd3,9'h1FF,1'b0}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_latch();
    @(negedge clk); cmd_set_en = 1'b1;
    @(negedge clk); cmd_set_en = 1'b0;
  endtask

  // Full status write of a new protect code, with a sequencer model.
  task automatic program_bp(input logic [1:0] nb, input bit wp_drop);
    logic [1:0] old;
    old = status[3:2];
    set_latch();
    @(negedge clk); st_byte = 1'b1; st_data = {4'h0, nb, 2'b00};
    @(negedge clk); st_byte = 1'b0; cs_rise = 1'b1;
    #1 chk("R7 sr_go at rise after byte", sr_go, 1);
    @(negedge clk); cs_rise = 1'b0; busy = 1'b1;
    chk("R7 latch cleared by status start", wel, 0);
    if (wp_drop) wp_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 old protect bits while busy", status[3:2], old);
      chk("R1 busy bit", status[0], 1);
    end
    busy = 1'b0;
    #1 chk("R8 old bits as busy drops", status[3:2], old);
    @(negedge clk);
    chk(wp_drop ? "R10 stored despite pin low" : "R8 new protect bits", status[3:2], nb);
    wp_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1'b1; init_n = 1'b1;
    @(negedge clk);
    chk("R1 R9 reset status", status, 8'hF0);
    chk("R3 latch clear after power-on", wel, 0);

    set_latch();
    chk("R2 set command", wel, 1);
    chk("R1 latch bit in status", status, 8'hF2);
    @(negedge clk); cmd_clr_en = 1'b1;
    @(negedge clk); cmd_clr_en = 1'b0;
    chk("R3 clear command", wel, 0);
    @(negedge clk); wp_n = 1'b0; cmd_set_en = 1'b1;
    @(negedge clk); cmd_set_en = 1'b0; wp_n = 1'b1;
    chk("R3 set ignored with pin low", wel, 0);
    set_latch();
    @(negedge clk); wp_n = 1'b0;
    @(negedge clk); wp_n = 1'b1;
    chk("R3 pin low clears latch", wel, 0);

    // Table walk over protect codes and addresses
    for (int i = 0; i < 24; i++) begin
      if (VEC[i][11:10] != status[3:2]) program_bp(VEC[i][11:10], 1'b0);
      @(negedge clk); chk_addr = VEC[i][9:1];
      #1 chk("R4 address verdict", chk_ok, VEC[i][0]);
    end

    // Array writes under code 01
    program_bp(2'd1, 1'b0);
    set_latch();
    @(negedge clk); arr_commit = 1'b1; arr_addr = 9'h180;
    #1 chk("R5 protected address no start", arr_go, 0);
    @(negedge clk); arr_commit = 1'b0;
    chk("R5 latch kept after dropped write", wel, 1);
    @(negedge clk); arr_commit = 1'b1; busy = 1'b1; arr_addr = 9'h17F;
    #1 chk("R5 busy blocks start", arr_go, 0);
    @(negedge clk); busy = 1'b0;
    #1 chk("R5 unprotected address starts", arr_go, 1);
    @(negedge clk); arr_commit = 1'b0;
    chk("R6 latch cleared by array start", wel, 0);
    @(negedge clk); arr_commit = 1'b1;
    #1 chk("R5 no start without latch", arr_go, 0);
    @(negedge clk); arr_commit = 1'b0;

    // Status write discarded by an extra bit
    set_latch();
    @(negedge clk); st_byte = 1'b1; st_data = 8'h0C;
    @(negedge clk); st_byte = 1'b0; bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0; cs_rise = 1'b1;
    #1 chk("R7 extra bit discards status write", sr_go, 0);
    @(negedge clk); cs_rise = 1'b0;
    chk("R7 protect bits unchanged", status[3:2], 1);
    chk("R7 latch kept when discarded", wel, 1);
    @(negedge clk); cmd_clr_en = 1'b1;
    @(negedge clk); cmd_clr_en = 1'b0; st_byte = 1'b1;
    @(negedge clk); st_byte = 1'b0; cs_rise = 1'b1;
    #1 chk("R7 no start without latch", sr_go, 0);
    @(negedge clk); cs_rise = 1'b0;

    // Pin drop during an active status programming cycle
    program_bp(2'd2, 1'b1);

    // Power-on keeps protect bits, delivery reset clears them
    set_latch();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    chk("R9 power-on clears latch", wel, 0);
    chk("R9 power-on keeps protect bits", status[3:2], 2);
    @(negedge clk); init_n = 1'b0;
    @(negedge clk); init_n = 1'b1;
    @(negedge clk);
    chk("R9 delivery reset gives 00", status[3:2], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule